// File: doc/BRIEF.md
# PCI Data Parity Error Reporter

This block checks even parity on every data phase of a 32-bit PCI interface. It raises the active-low parity error output and the sticky detected-parity-error status bit. Each data phase is qualified by its role, which the surrounding device supplies. In the target role only write data that this device claimed is checked. In the master role only read data on transactions this device started is checked. Data phases in any other role or direction are not checked.

The parity output for a data phase arrives one clock after the data. The comparison is made on that clock, so the error pulse appears two clocks after the faulty data phase. Consecutive faulty phases in a burst each produce their own pulse. The pulse is gated by the parity error response enable. The status bit records every qualified error whatever the enable says, and software clears it by writing a one to it. The error output has an output-enable that stays asserted for one clock after the last pulse, so the line is driven high before it is released.

Top module: `pci_dperr_rpt`

## Requirements
- R1: In the target role an error is reported only when `tgt_claim_i` is 1 and `rd_i` is 0 (write). An unclaimed phase or a target read with bad parity causes neither a pulse nor a status set.
- R2: In the master role an error is reported only when `mst_own_i` is 1 and `rd_i` is 1 (read). A master write, or a read on a transaction this device did not start, causes neither a pulse nor a status set.
- R3: A qualified error drives `perr_no` low for exactly one clock. If the data phase is sampled at clock edge k and its parity at edge k+1, `perr_no` is low from edge k+1 to edge k+2.
- R4: `perr_no` is asserted only while `perr_resp_en_i` is 1. `dpe_o` is set on a qualified error even when the enable is 0.
- R5: `dpe_o` stays 1 until `dpe_clr_i` is sampled high or reset. When a clear and a new error fall on the same edge, `dpe_o` stays 1.
- R6: Back-to-back faulty data phases each give their own one-clock low on `perr_no`, in phase order.
- R7: Parity is even across `ad_i` and `cbe_ni`. An error exists when `par_i` differs from the XOR of those 36 bits. Every byte-enable pattern on `cbe_ni` is accepted, and correct parity never raises an error.
- R8: `perr_oe_o` is 1 while `perr_no` is low and for one clock after its last low clock, then 0. `perr_no` is 1 whenever it is not asserting.
- R9: After reset `perr_no` is 1, `perr_oe_o` is 0 and `dpe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PCI clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ad_i | input | 32 | Address/data bus in the data phase |
| cbe_ni | input | 4 | Active-low byte enables in the data phase |
| par_i | input | 1 | Parity for the previous clock's data phase |
| data_valid_i | input | 1 | A data phase completes this clock |
| tgt_claim_i | input | 1 | Device claimed the access as target with DEVSEL# driven |
| mst_own_i | input | 1 | Device initiated the transaction as master |
| rd_i | input | 1 | 1 = read transaction, 0 = write |
| perr_resp_en_i | input | 1 | Parity error response enable from the command register |
| dpe_clr_i | input | 1 | Write-one-to-clear strobe for the status bit |
| perr_no | output | 1 | Active-low parity error output |
| perr_oe_o | output | 1 | Output-enable for `perr_no` |
| dpe_o | output | 1 | Detected parity error status bit |

## Verification
A corrupted stage register or a wrong role gate shows up two clocks after the data phase. It appears as a missing, extra or mis-placed low clock on `perr_no`, and the status bit moves at the same edge. A broken status register shows up one clock after a clear or an error, when `dpe_o` fails to hold, fails to set or lets the clear win. A faulty output-enable shows up within one or two clocks of a pulse, as a line released too early or left driven.

// File: rtl/pci_dperr_pkg.sv
package pci_dperr_pkg;
  // one in-flight data phase awaiting its parity bit
  typedef struct packed {
    logic qual;     // phase is checked in its role
    logic par_calc; // XOR of AD and C/BE# in the phase
  } dphase_t;
endpackage

// File: rtl/pci_dperr_parity.sv
module pci_dperr_parity #(
  parameter int unsigned VEC_W  = 36,
  parameter int unsigned LANE_W = 8
) (
  input  logic [VEC_W-1:0] vec_i,
  output logic             par_o
);
  localparam int unsigned LANES = (VEC_W + LANE_W - 1) / LANE_W;
  localparam int unsigned PAD_W = LANES * LANE_W;

  logic [PAD_W-1:0] pad;
  logic [LANES-1:0] lane_par;

  assign pad = {{(PAD_W-VEC_W){1'b0}}, vec_i};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_par[l] = ^pad[l*LANE_W +: LANE_W];
  end

  assign par_o = ^lane_par;
endmodule

// File: rtl/pci_dperr_qual.sv
module pci_dperr_qual (
  input  logic data_valid_i,
  input  logic tgt_claim_i,
  input  logic mst_own_i,
  input  logic rd_i,
  output logic qual_o
);
  logic tgt_chk, mst_chk;
  assign tgt_chk = tgt_claim_i & ~rd_i; // R1 target: claimed writes
  assign mst_chk = mst_own_i & rd_i;    // R2 master: own reads
  assign qual_o  = data_valid_i & (tgt_chk | mst_chk);
endmodule

// File: rtl/pci_dperr_drive.sv
module pci_dperr_drive (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic en_i,
  output logic perr_no,
  output logic perr_oe_o
);
  logic perr_n_q, oe_q, assert_now;

  assign assert_now = fire_i & en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      perr_n_q <= 1'b1;
      oe_q     <= 1'b0;
    end else begin
      perr_n_q <= ~assert_now;
      oe_q     <= assert_now | ~perr_n_q; // hold drive one clock past last low
    end
  end

  assign perr_no   = perr_n_q;
  assign perr_oe_o = oe_q;

  AST_LOW_IS_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !perr_no |-> perr_oe_o); // R8
  AST_TAIL_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !perr_no |=> perr_oe_o); // R8
  AST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (perr_no && $past(perr_no)) |-> !perr_oe_o); // R8
  AST_PERR_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !perr_no |-> $past(en_i)); // R4
endmodule

// File: rtl/pci_dperr_status.sv
module pci_dperr_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic dpe_o
);
  logic dpe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    dpe_q <= 1'b0;
    else if (set_i) dpe_q <= 1'b1; // new error beats clear
    else if (clr_i) dpe_q <= 1'b0;
  end

  assign dpe_o = dpe_q;

  AST_DPE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dpe_o && !clr_i) |=> dpe_o); // R5
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> dpe_o); // R5
endmodule

// File: rtl/pci_dperr_rpt.sv
module pci_dperr_rpt
  import pci_dperr_pkg::*;
#(
  parameter int unsigned AD_W = 32,
  parameter int unsigned BE_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AD_W-1:0] ad_i,
  input  logic [BE_W-1:0] cbe_ni,
  input  logic            par_i,
  input  logic            data_valid_i,
  input  logic            tgt_claim_i,
  input  logic            mst_own_i,
  input  logic            rd_i,
  input  logic            perr_resp_en_i,
  input  logic            dpe_clr_i,
  output logic            perr_no,
  output logic            perr_oe_o,
  output logic            dpe_o
);
  localparam int unsigned VEC_W = AD_W + BE_W;

  logic    par_calc, qual, fire;
  dphase_t stg_q;

  pci_dperr_parity #(.VEC_W(VEC_W), .LANE_W(8)) u_parity (
    .vec_i ({cbe_ni, ad_i}),
    .par_o (par_calc)
  );

  pci_dperr_qual u_qual (
    .data_valid_i (data_valid_i),
    .tgt_claim_i  (tgt_claim_i),
    .mst_own_i    (mst_own_i),
    .rd_i         (rd_i),
    .qual_o       (qual)
  );

  // stage holds the phase until its PAR arrives next clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= '{qual: qual, par_calc: par_calc};
  end

  assign fire = stg_q.qual & (stg_q.par_calc ^ par_i);

  pci_dperr_drive u_drive (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fire_i    (fire),
    .en_i      (perr_resp_en_i),
    .perr_no   (perr_no),
    .perr_oe_o (perr_oe_o)
  );

  pci_dperr_status u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (fire),
    .clr_i  (dpe_clr_i),
    .dpe_o  (dpe_o)
  );

  AST_PERR_HAS_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !perr_no |-> $past(stg_q.qual)); // R3
  AST_PERR_SETS_DPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !perr_no |-> dpe_o); // R4
endmodule

// File: tb/pci_dperr_rpt_tb.sv
module pci_dperr_rpt_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ad = '0;
  logic [3:0]  cbe_n = '1;
  logic        par = 1'b0, valid = 1'b0, tgt = 1'b0, mst = 1'b0, rd = 1'b0;
  logic        en = 1'b1, clr = 1'b0;
  logic        perr_n, oe, dpe;
  int          checks = 0, fails = 0;

  always #4 clk = ~clk; // 125 MHz

  pci_dperr_rpt dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ad_i(ad), .cbe_ni(cbe_n), .par_i(par),
    .data_valid_i(valid), .tgt_claim_i(tgt), .mst_own_i(mst), .rd_i(rd),
    .perr_resp_en_i(en), .dpe_clr_i(clr),
    .perr_no(perr_n), .perr_oe_o(oe), .dpe_o(dpe)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  function automatic logic even_par(input logic [31:0] a, input logic [3:0] b);
    return ^{b, a};
  endfunction

  task automatic clear_dpe();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk("R5", "dpe after clear", dpe, 1'b0);
  endtask

  // one data phase in given role; checks pulse timing, output-enable and status
  task automatic single(input string req, input logic t, input logic m, input logic r,
                        input logic bad, input logic [3:0] be, input logic exp_err);
    logic [31:0] a;
    a = $urandom();
    @(negedge clk);
    ad = a; cbe_n = be; valid = 1'b1; tgt = t; mst = m; rd = r;
    @(negedge clk);
    valid = 1'b0; tgt = 1'b0; mst = 1'b0;
    par = even_par(a, be) ^ bad;
    chk(req, "perr before window", perr_n, 1'b1);
    @(negedge clk);
    chk(req, "perr in window", perr_n, ~(exp_err & en));
    chk(req, "oe in window", oe, exp_err & en);
    chk(req, "dpe after phase", dpe, exp_err);
    @(negedge clk);
    chk(req, "perr one clock later", perr_n, 1'b1);
    chk(req, "oe tail", oe, exp_err & en);
    @(negedge clk);
    chk(req, "oe released", oe, 1'b0);
  endtask

  task automatic t_reset();
    chk("R9", "perr reset", perr_n, 1'b1);
    chk("R9", "oe reset", oe, 1'b0);
    chk("R9", "dpe reset", dpe, 1'b0);
  endtask

  task automatic t_target();
    single("R1", 1, 0, 0, 1, 4'h0, 1); // R3 R8 timing as well
    clear_dpe();
    single("R1", 0, 0, 0, 1, 4'h0, 0); // unclaimed
    single("R1", 1, 0, 1, 1, 4'h0, 0); // target read
  endtask

  task automatic t_master();
    single("R2", 0, 1, 1, 1, 4'h3, 1);
    clear_dpe();
    single("R2", 0, 1, 0, 1, 4'h3, 0); // master write
    single("R2", 0, 0, 1, 1, 4'h3, 0); // not initiated
  endtask

  task automatic t_byte_enables();
    for (int b = 0; b < 16; b++) single("R7", 1, 0, 0, 0, 4'(b), 0);
    single("R7", 1, 0, 0, 1, 4'hA, 1);
    clear_dpe();
  endtask

  task automatic t_enable_off();
    en = 1'b0;
    single("R4", 0, 1, 1, 1, 4'h5, 1);
    en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5", "dpe sticky idle", dpe, 1'b1);
    clear_dpe();
  endtask

  task automatic t_set_wins();
    logic [31:0] a;
    a = 32'h1234_5678;
    @(negedge clk);
    ad = a; cbe_n = 4'h0; valid = 1'b1; tgt = 1'b1; rd = 1'b0;
    @(negedge clk);
    valid = 1'b0; tgt = 1'b0; par = ~even_par(a, 4'h0); clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R5", "set beats clear", dpe, 1'b1);
    clear_dpe();
  endtask

  // burst of back-to-back phases, parity of phase i driven with phase i+1
  task automatic t_burst();
    logic [31:0] a[5];
    logic [3:0]  b[5];
    logic        bad[5];
    bad = '{1, 1, 0, 1, 0};
    for (int i = 0; i < 5; i++) begin a[i] = $urandom(); b[i] = 4'(i * 3); end
    for (int j = 0; j < 7; j++) begin
      @(negedge clk);
      if (j >= 2) begin
        chk("R6", "burst perr", perr_n, ~bad[j-2]);
        chk("R8", "burst oe", oe, bad[j-2] | ((j >= 3) ? bad[j-3] : 1'b0));
      end
      if (j < 5) begin
        ad = a[j]; cbe_n = b[j]; valid = 1'b1; mst = 1'b1; rd = 1'b1;
      end else begin
        valid = 1'b0; mst = 1'b0;
      end
      if (j >= 1 && j <= 5) par = even_par(a[j-1], b[j-1]) ^ bad[j-1];
    end
    chk("R6", "burst dpe", dpe, 1'b1);
    clear_dpe();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_target();
    t_master();
    t_byte_enables();
    t_enable_off();
    t_set_wins();
    t_burst();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule